// File: doc/BRIEF.md
# Serial Stereo Volume Control Receiver

This block is the digital front end of a two-channel stereo attenuator. A host sends it commands over three wires: a chip-enable strobe, a serial clock and a data line. Each command starts with an 8-bit device address, which is clocked in while the strobe is low. A 16-bit word follows while the strobe is high. The word holds an attenuation code, a two-bit channel steer and six reserved bits. The attenuation setting is updated only when the strobe falls, and only if the whole frame checks out.

Each channel keeps its setting in a register. The block decodes that setting into a one-hot selection with one line per legal position, which drives the switch network of a resistor-ladder attenuator. The serial lines are oversampled by a fast system clock, so the host's serial clock never clocks any logic. After reset both channels hold no valid setting. A combined ready flag rises once both channels have received one, and a system can use it to hold an external mute until then.

Top module: `svc_volume_rx`

## Requirements
- R1: A frame consists of exactly 8 address bits clocked while chip enable is low, followed by exactly 16 data bits clocked while chip enable is high. Each field is sent least significant bit first, and the data line is sampled on the rising edge of the serial clock. An accepted frame takes effect on the falling edge of chip enable.
- R2: A frame is accepted only if its address equals 0x88, that is the bits 0,0,0,1,0,0,0,1 in transmit order. Any other address leaves every output unchanged.
- R3: Data bit 8 steers the word to the right channel and data bit 9 steers it to the left channel. With both bits set, both channels are written. With both bits clear, the frame changes nothing.
- R4: A frame whose data bits 15 down to 10 are not all zero changes nothing.
- R5: The attenuation code is data bits 7 to 0, and its value is the attenuation in dB. The legal codes are 0 to 50, the even values 52 to 78, and 80, which means mute. Any other code is discarded and the previous setting is kept.
- R6: Each channel's tap output is 66 bits wide. A valid channel sets exactly the bit at its position index and no other bit. The index is the code itself for codes 0 to 50, 25 plus half the code for codes 52 to 78, and 65 for the mute code. An invalid channel drives all 66 bits to zero.
- R7: After reset, both valid flags, the ready output and both codes are zero. A channel's valid flag rises with its first accepted write and then stays high. The ready output is high exactly when both channels are valid.
- R8: A frame is dropped if the address count is not 8 or the data count is not 16 when chip enable falls.
- R9: The outputs do not change while chip enable is still high, even after 16 data bits have been received.
- R10: If a serial clock rise reaches the system clock domain in the same cycle as a chip-enable edge, the bit is counted in the phase that the edge ends. The frame is then judged with that bit included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_ce | input | 1 | Chip-enable strobe: low during the address, high during the data |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data line |
| code_l | output | 8 | Stored attenuation code for the left channel |
| code_r | output | 8 | Stored attenuation code for the right channel |
| tap_l | output | 66 | One-hot ladder tap selection for the left channel |
| tap_r | output | 66 | One-hot ladder tap selection for the right channel |
| valid_l | output | 1 | The left channel has received a setting |
| valid_r | output | 1 | The right channel has received a setting |
| ready | output | 1 | Both channels are valid |

## Verification
Two events can fall in the same system cycle: the strobe edge that closes a phase and the serial clock rise that carries the last bit of that phase. After synchronization they also arrive together. The bench provokes this by changing the serial clock and the chip-enable line on the same system clock edge. It does this for the eighth address bit at the strobe rise and for the sixteenth data bit at the strobe fall. It then judges the result by whether the frame commits exactly as a frame with ordinary timing would: the bit must have been counted in the phase that was closing.

// File: rtl/svc_pkg.sv
// svc_pkg: shared constants and code helpers for the serial volume receiver.
// Assumes an 8-bit attenuation code whose value is the attenuation in dB.
package svc_pkg;
    localparam int CODE_W    = 8;
    localparam int N_POS     = 66;
    localparam int POS_W     = $clog2(N_POS);
    localparam int SEL_W     = 2;
    localparam int N_CH      = 2;
    localparam int FINE_MAX  = 50;
    localparam int COARSE_LO = 52;
    localparam int COARSE_HI = 78;
    localparam int MUTE_CODE = 80;

    // True for codes that map to a ladder position.
    function automatic logic code_legal(input logic [CODE_W-1:0] c);
        if (c <= CODE_W'(FINE_MAX)) return 1'b1;
        if (c >= CODE_W'(COARSE_LO) && c <= CODE_W'(COARSE_HI) && !c[0]) return 1'b1;
        return c == CODE_W'(MUTE_CODE);
    endfunction

    // Ladder position index of a legal code.
    function automatic logic [POS_W-1:0] code_to_pos(input logic [CODE_W-1:0] c);
        if (c <= CODE_W'(FINE_MAX)) return POS_W'(c);
        if (c == CODE_W'(MUTE_CODE)) return POS_W'(N_POS - 1);
        return POS_W'((c >> 1) + CODE_W'(FINE_MAX / 2));
    endfunction
endpackage

// File: rtl/svc_sync.sv
// svc_sync: multi-stage synchronizer for a bundle of asynchronous lines.
// Assumes each line stays stable for many system clocks, so there is no
// need for cross-bit coherence.
module svc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the asynchronous lines through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/svc_frame_rx.sv
// svc_frame_rx: counts and shifts the address and data phases of a serial
// frame, and emits a one-cycle commit with the decoded fields when a
// well-formed frame closes. Assumes inputs that are already synchronized.
// A clock rise that arrives with a strobe edge belongs to the phase before
// the edge.
module svc_frame_rx
    import svc_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 16,
    parameter logic [7:0]  DEV_ADDR = 8'h88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_lvl,
    input  logic              sck_lvl,
    input  logic              sda_lvl,
    output logic              commit,
    output logic [CODE_W-1:0] code,
    output logic [SEL_W-1:0]  sel
);
    localparam int TEST_W = DATA_W - CODE_W - SEL_W;
    localparam int ACNT_W = $clog2(ADDR_W + 2);
    localparam int DCNT_W = $clog2(DATA_W + 2);
    localparam logic [ACNT_W-1:0] A_MAX = '1;
    localparam logic [DCNT_W-1:0] D_MAX = '1;

    logic              ce_q, sck_q;
    logic              ce_rise, ce_fall, sck_rise, abit, dbit;
    logic [ADDR_W-1:0] a_sr, a_sr_nx;
    logic [DATA_W-1:0] d_sr, d_sr_nx;
    logic [ACNT_W-1:0] a_cnt, a_cnt_nx;
    logic [DCNT_W-1:0] d_cnt, d_cnt_nx;
    logic              addr_ok, frame_ok;

    // Edge detection; ce_q is the phase that an edge in this cycle closes.
    assign ce_rise  = ce_lvl & ~ce_q;
    assign ce_fall  = ~ce_lvl & ce_q;
    assign sck_rise = sck_lvl & ~sck_q;
    assign abit     = sck_rise & ~ce_q;
    assign dbit     = sck_rise & ce_q;

    // Next shift and count values, including a bit that arrives with an edge.
    always_comb begin
        a_sr_nx  = abit ? {sda_lvl, a_sr[ADDR_W-1:1]} : a_sr;
        d_sr_nx  = dbit ? {sda_lvl, d_sr[DATA_W-1:1]} : d_sr;
        a_cnt_nx = (abit && a_cnt != A_MAX) ? a_cnt + 1'b1 : a_cnt;
        d_cnt_nx = (dbit && d_cnt != D_MAX) ? d_cnt + 1'b1 : d_cnt;
    end

    // Check the whole frame at the closing edge.
    always_comb begin
        frame_ok = addr_ok
                && d_cnt_nx == DCNT_W'(DATA_W)
                && d_sr_nx[DATA_W-1 -: TEST_W] == '0
                && d_sr_nx[CODE_W +: SEL_W] != '0
                && code_legal(d_sr_nx[CODE_W-1:0]);
    end

    // Phase bookkeeping, the address check and the commit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q    <= 1'b0;
            sck_q   <= 1'b0;
            a_sr    <= '0;
            d_sr    <= '0;
            a_cnt   <= '0;
            d_cnt   <= '0;
            addr_ok <= 1'b0;
            commit  <= 1'b0;
            code    <= '0;
            sel     <= '0;
        end else begin
            ce_q   <= ce_lvl;
            sck_q  <= sck_lvl;
            a_sr   <= a_sr_nx;
            d_sr   <= d_sr_nx;
            a_cnt  <= a_cnt_nx;
            d_cnt  <= d_cnt_nx;
            commit <= 1'b0;
            if (ce_rise) begin
                addr_ok <= (a_cnt_nx == ACNT_W'(ADDR_W)) && (a_sr_nx == DEV_ADDR);
                a_cnt   <= '0;
                d_cnt   <= '0;
            end
            if (ce_fall) begin
                addr_ok <= 1'b0;
                a_cnt   <= '0;
                d_cnt   <= '0;
                commit  <= frame_ok;
                code    <= d_sr_nx[CODE_W-1:0];
                sel     <= d_sr_nx[CODE_W +: SEL_W];
            end
        end
    end

    AST_COMMIT_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !ce_q) else $error("commit while strobe high"); // R9
    AST_COMMIT_HAS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> sel != '0) else $error("commit with no channel"); // R3
    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit) else $error("commit longer than a cycle"); // R1
endmodule

// File: rtl/svc_chan_reg.sv
// svc_chan_reg: holds one channel's attenuation code and valid flag, and
// decodes the code into a one-hot ladder tap selection. Assumes that every
// write carries a legal code.
module svc_chan_reg
    import svc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    output logic [CODE_W-1:0] code_q,
    output logic              valid_q,
    output logic [N_POS-1:0]  tap
);
    logic [POS_W-1:0] pos;

    // Store the setting and mark the channel valid on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            valid_q <= 1'b0;
        end else if (wr_en) begin
            code_q  <= wr_code;
            valid_q <= 1'b1;
        end
    end

    assign pos = code_to_pos(code_q);

    // One comparator for each ladder position.
    for (genvar p = 0; p < N_POS; p++) begin : g_tap
        assign tap[p] = valid_q && (pos == POS_W'(p));
    end

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> code_legal(code_q)) else $error("illegal code stored"); // R5
    AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(code_q)) else $error("code moved without write"); // R9
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> valid_q) else $error("valid dropped"); // R7
    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $countones(tap) == 1) else $error("tap not one-hot"); // R6
    AST_TAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> tap == '0) else $error("tap set while invalid"); // R6
endmodule

// File: rtl/svc_volume_rx.sv
// svc_volume_rx: top of the serial stereo volume control receiver. It
// synchronizes the three serial lines, decodes frames, and steers each
// accepted setting to the right and/or left channel register.
// Assumes that the serial clock is far slower than clk.
module svc_volume_rx
    import svc_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 16,
    parameter logic [7:0] DEV_ADDR    = 8'h88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_ce,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [CODE_W-1:0] code_l,
    output logic [CODE_W-1:0] code_r,
    output logic [N_POS-1:0]  tap_l,
    output logic [N_POS-1:0]  tap_r,
    output logic              valid_l,
    output logic              valid_r,
    output logic              ready
);
    // Channel index 0 is right (steer bit 0), index 1 is left (steer bit 1).
    localparam int CH_R = 0;
    localparam int CH_L = 1;

    logic [2:0]              lines;
    logic                    commit;
    logic [CODE_W-1:0]       f_code;
    logic [SEL_W-1:0]        f_sel;
    logic [N_CH-1:0][CODE_W-1:0] ch_code;
    logic [N_CH-1:0][N_POS-1:0]  ch_tap;
    logic [N_CH-1:0]         ch_valid;

    svc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_dat, ser_clk, ser_ce}),
        .sync_out (lines)
    );

    svc_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_lvl  (lines[0]),
        .sck_lvl (lines[1]),
        .sda_lvl (lines[2]),
        .commit  (commit),
        .code    (f_code),
        .sel     (f_sel)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        svc_chan_reg u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (commit && f_sel[ch]),
            .wr_code (f_code),
            .code_q  (ch_code[ch]),
            .valid_q (ch_valid[ch]),
            .tap     (ch_tap[ch])
        );
    end

    assign code_r  = ch_code[CH_R];
    assign code_l  = ch_code[CH_L];
    assign tap_r   = ch_tap[CH_R];
    assign tap_l   = ch_tap[CH_L];
    assign valid_r = ch_valid[CH_R];
    assign valid_l = ch_valid[CH_L];
    assign ready   = &ch_valid;

    AST_READY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(commit)) else $error("ready rose without write"); // R7
endmodule

// File: tb/svc_volume_rx_tb.sv
module svc_volume_rx_tb;
    localparam int H = 5;   // serial half period in system clocks

    logic clk = 0, rst_n = 0;
    logic ser_ce = 0, ser_clk = 0, ser_dat = 0;
    logic [7:0]  code_l, code_r;
    logic [65:0] tap_l, tap_r;
    logic valid_l, valid_r, ready;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int e_cl = 0, e_cr = 0;
    bit e_vl = 0, e_vr = 0;

    always #10 clk = ~clk;

    svc_volume_rx u_dut (
        .clk(clk), .rst_n(rst_n), .ser_ce(ser_ce), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .code_l(code_l), .code_r(code_r), .tap_l(tap_l), .tap_r(tap_r),
        .valid_l(valid_l), .valid_r(valid_r), .ready(ready)
    );

    function automatic bit legal_b(int c);
        return (c >= 0 && c <= 50) || (c >= 52 && c <= 78 && c % 2 == 0) || c == 80;
    endfunction

    // Position is the number of legal codes below c.
    function automatic int pos_b(int c);
        int n = 0;
        for (int k = 0; k < c; k++) if (legal_b(k)) n++;
        return n;
    endfunction

    function automatic logic [65:0] tap_b(bit v, int c);
        return v ? (66'd1 << pos_b(c)) : 66'd0;
    endfunction

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, string what, logic [65:0] act, logic [65:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "code_l", 66'(code_l), 66'(e_cl));
        chk(tag, "code_r", 66'(code_r), 66'(e_cr));
        chk(tag, "valid_l", 66'(valid_l), 66'(e_vl));
        chk(tag, "valid_r", 66'(valid_r), 66'(e_vr));
        chk(tag, "ready", 66'(ready), 66'(e_vl & e_vr));
        chk(tag, "tap_l", tap_l, tap_b(e_vl, e_cl));
        chk(tag, "tap_r", tap_r, tap_b(e_vr, e_cr));
    endtask

    // Model of the frame rules.
    task automatic model(logic [7:0] a, int na, logic [15:0] d, int nd);
        if (a == 8'h88 && na == 8 && nd == 16 && d[15:10] == 0 && d[9:8] != 0
            && legal_b(int'(d[7:0]))) begin
            if (d[8]) begin e_cr = d[7:0]; e_vr = 1; end
            if (d[9]) begin e_cl = d[7:0]; e_vl = 1; end
        end
    endtask

    task automatic send(logic [7:0] a, int na, logic [15:0] d, int nd,
                        bit co_a, bit co_d, bit midchk);
        wait_clk(2 * H);
        for (int i = 0; i < na; i++) begin
            ser_dat = a[i % 8];
            wait_clk(H);
            ser_clk = 1;
            if (co_a && i == na - 1) ser_ce = 1;
            wait_clk(H);
            ser_clk = 0;
        end
        if (!(co_a && na > 0)) begin wait_clk(H); ser_ce = 1; end
        wait_clk(H);
        for (int i = 0; i < nd; i++) begin
            ser_dat = d[i % 16];
            wait_clk(H);
            ser_clk = 1;
            if (co_d && i == nd - 1) ser_ce = 0;
            wait_clk(H);
            ser_clk = 0;
        end
        if (midchk) begin wait_clk(4 * H); check_all("R9 strobe still high"); end
        if (!(co_d && nd > 0)) begin wait_clk(H); ser_ce = 0; end
        wait_clk(4 * H);
        model(a, na, d, nd);
    endtask

    task automatic frame(logic [7:0] a, logic [15:0] d, string tag);
        send(a, 8, d, 16, 0, 0, 0);
        check_all(tag);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        wait_clk(5);
        rst_n = 1;
        wait_clk(3);
        check_all("R7 reset");
        frame(8'h88, 16'h0200 | 16'd0, "R1 R3 R7 left only, ready low");
        frame(8'h88, 16'h0100 | 16'd80, "R3 R5 R6 R7 right mute");
        frame(8'h88, 16'h0300 | 16'd50, "R3 R6 both 50");
        frame(8'h88, 16'h0200 | 16'd52, "R6 left 52");
        frame(8'h88, 16'h0100 | 16'd78, "R6 right 78");
        frame(8'h89, 16'h0300 | 16'd7, "R2 wrong address");
        frame(8'h11, 16'h0300 | 16'd7, "R2 reversed address");
        frame(8'h88, 16'h0000 | 16'd7, "R3 no channel");
        frame(8'h88, 16'h0700 | 16'd7, "R4 test bit 10");
        frame(8'h88, 16'h8300 | 16'd7, "R4 test bit 15");
        frame(8'h88, 16'h0300 | 16'd51, "R5 illegal 51");
        frame(8'h88, 16'h0300 | 16'd79, "R5 illegal 79");
        frame(8'h88, 16'h0300 | 16'd81, "R5 illegal 81");
        frame(8'h88, 16'h0300 | 16'd255, "R5 illegal 255");
        send(8'h88, 8, 16'h0300 | 16'd9, 15, 0, 0, 0); check_all("R8 15 data bits");
        send(8'h88, 8, 16'h0300 | 16'd9, 17, 0, 0, 0); check_all("R8 17 data bits");
        send(8'h88, 7, 16'h0300 | 16'd9, 16, 0, 0, 0); check_all("R8 7 address bits");
        send(8'h88, 9, 16'h0300 | 16'd9, 16, 0, 0, 0); check_all("R8 9 address bits");
        send(8'h88, 8, 16'h0300 | 16'd12, 16, 0, 0, 1); check_all("R9 after fall");
        send(8'h88, 8, 16'h0200 | 16'd33, 16, 1, 0, 0); check_all("R10 address edge");
        send(8'h88, 8, 16'h0100 | 16'd44, 16, 0, 1, 0); check_all("R10 data edge");
        send(8'h88, 8, 16'h0300 | 16'd60, 16, 1, 1, 0); check_all("R10 both edges");
        for (int it = 0; it < 60; it++) begin
            int r, na, nd;
            logic [7:0] a;
            logic [15:0] d;
            r  = $urandom % 16;
            a  = (r == 0) ? 8'($urandom) : 8'h88;
            na = (r == 1) ? 7 : (r == 2) ? 9 : 8;
            nd = (r == 4) ? 15 : (r == 5) ? 17 : 16;
            d  = {6'(r == 3 ? 1 + $urandom % 63 : 0), 2'($urandom), 8'($urandom % 96)};
            send(a, na, d, nd, 1'($urandom), 1'($urandom), 0);
            check_all("R1 R5 R6 random");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule